// File: doc/BRIEF.md
# UART receive status flag controller

This block stands between the shift register of a serial receiver and a processor-style register interface. When the shifter reports a finished character, the block decides whether that character enters the receive buffer. It then updates four status flags: data ready, overrun, noise and framing error. Each flag is set, ranked and cleared by its own rule.

Software clears the error flags with a two-step sequence. It reads the status address, then the data address. The status read records which error flags it saw. The data read that follows clears only those flags, so an error that arrives between the two reads is kept.

The data address has two uses. Reads return the receive buffer, and writes fill a separate transmit holding register. A mode bit enables nine-bit characters; in that mode the extra bit is stored beside the data byte.

Top module: `uart_rx_status`

## Requirements
- R1: After a synchronous reset all four flags, the ninth-bit output, the mode bit, the receive buffer, the transmit register and the clear sequence are zero or disarmed.
- R2: A completion strobe that arrives while data-ready and framing error are both clear loads `ch_bits[7:0]` into the receive buffer and sets data-ready on the next cycle.
- R3: A completion strobe that arrives while data-ready is set and framing error is clear sets overrun on the next cycle. The new character is discarded, and the buffer, ninth bit, noise and framing flags are left unchanged.
- R4: Noise is set only by a character that is loaded into the buffer and arrives with `ch_noise` high. It becomes visible in the same cycle as data-ready and is never set by a discarded character.
- R5: Framing error is set, together with data-ready, by a loaded character whose `ch_stop_ok` is low. A character that overruns leaves framing error clear, whatever its stop bit.
- R6: While framing error is set, every completion strobe is ignored: the buffer, data-ready and overrun do not change.
- R7: A status read records the error flags that are set at that moment. The next data read clears exactly those flags. A flag that is set later, including in the same cycle as the data read, stays set.
- R8: A data read with no status read before it in the sequence clears no error flag. Every data read clears data-ready unless a character is loaded in the same cycle.
- R9: When a status read and a data read come in the same cycle, the data read uses the arming left by earlier reads. The status read then arms a new sequence.
- R10: `mode_we` writes `mode_din` into the nine-bit mode bit. A loaded character stores `ch_bits[8]` in the ninth-bit output while that mode bit is set. While the mode bit is clear, the ninth-bit output keeps its value.
- R11: A data write stores `wr_din` in the transmit holding register and does not change the receive buffer or any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_done | input | 1 | One-cycle strobe: the shifter has finished a character |
| ch_bits | input | DATA_W+1 | Received character; the top bit is the ninth bit |
| ch_noise | input | 1 | Noise was seen on some bit of this character |
| ch_stop_ok | input | 1 | The stop bit was found |
| rd_stat | input | 1 | Read strobe for the status address |
| rd_data | input | 1 | Read strobe for the data address |
| wr_data | input | 1 | Write strobe for the data address |
| wr_din | input | DATA_W | Write data for the transmit holding register |
| mode_we | input | 1 | Write strobe for the nine-bit mode bit |
| mode_din | input | 1 | New value of the nine-bit mode bit |
| rdrf_o | output | 1 | Receive data ready |
| ovr_o | output | 1 | Overrun flag |
| nf_o | output | 1 | Noise flag |
| fe_o | output | 1 | Framing error flag |
| bit9_o | output | 1 | Stored ninth bit |
| mode9_o | output | 1 | Nine-bit mode bit |
| rx_data_o | output | DATA_W | Receive buffer |
| tx_data_o | output | DATA_W | Transmit holding register |

## Verification
Directed sequences run the load path in three situations: on an empty buffer, on a full buffer, and while a framing error is pending. These show apart loading, overrun and blocking. Characters that arrive with a bad stop bit on a full buffer check that overrun outranks framing error. Read orders are varied: a status read then a data read, a data read alone, a flag that sets between the two reads, and both reads in the same cycle. These separate a correct snapshot clear from one that clears everything or nothing. A long random run then mixes all strobes against a behavioural model, so that collisions such as a load, a read and a mode write in one cycle are covered too.

// File: rtl/rxsf_pkg.sv
package rxsf_pkg;

  // Error flag group shared by the flag keeper and the clear sequencer
  typedef struct packed {
    logic ovr;
    logic nf;
    logic fe;
  } err_t;

  localparam err_t ERR_NONE = '{ovr: 1'b0, nf: 1'b0, fe: 1'b0};

endpackage

// File: rtl/rxsf_clear_seq.sv
module rxsf_clear_seq
  import rxsf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rd_stat,
  input  logic rd_data,
  input  err_t err_i,
  output err_t clr_o
);

  logic armed_q;
  err_t snap_q;

  // A status read arms the sequence and records the flags it saw.
  // A data read disarms it. A status read in the same cycle arms again.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      snap_q  <= ERR_NONE;
    end else begin
      if (rd_stat) begin
        armed_q <= 1'b1;
        snap_q  <= err_i;
      end else if (rd_data) begin
        armed_q <= 1'b0;
      end
    end
  end

  always_comb begin
    clr_o = ERR_NONE;
    if (rd_data && armed_q) clr_o = snap_q;
  end

endmodule

// File: rtl/rxsf_flags.sv
module rxsf_flags
  import rxsf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ch_done,
  input  logic ch_noise,
  input  logic ch_stop_ok,
  input  logic rd_data,
  input  err_t clr_i,
  output logic rdrf_q,
  output err_t err_q,
  output logic load_o
);

  logic ovr_ev;

  // Order of precedence: a pending framing error drops the character,
  // then a full buffer turns it into an overrun, otherwise it is loaded.
  assign load_o = ch_done && !err_q.fe && !rdrf_q;
  assign ovr_ev = ch_done && !err_q.fe && rdrf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdrf_q <= 1'b0;
      err_q  <= ERR_NONE;
    end else begin
      if (load_o)       rdrf_q <= 1'b1;
      else if (rd_data) rdrf_q <= 1'b0;
      err_q.ovr <= (err_q.ovr & ~clr_i.ovr) | ovr_ev;
      err_q.nf  <= (err_q.nf  & ~clr_i.nf)  | (load_o & ch_noise);
      err_q.fe  <= (err_q.fe  & ~clr_i.fe)  | (load_o & ~ch_stop_ok);
    end
  end

  AST_NF_WITH_RDRF: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q.nf) |-> rdrf_q); // R4
  AST_FE_WITH_RDRF: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q.fe) |-> $rose(rdrf_q)); // R5
  AST_OVR_HIDES_FE: assert property (@(posedge clk) disable iff (rst)
    (ch_done && rdrf_q && !err_q.fe) |=> !err_q.fe); // R5

endmodule

// File: rtl/rxsf_rx_buf.sv
module rxsf_rx_buf #(
  parameter int DW       = 8,
  parameter bit NINTH_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          mode9,
  input  logic [DW:0]   din,
  output logic [DW-1:0] data_q,
  output logic          bit9_q
);

  always_ff @(posedge clk) begin
    if (rst)       data_q <= '0;
    else if (load) data_q <= din[DW-1:0];
  end

  generate
    if (NINTH_EN) begin : g_ninth
      always_ff @(posedge clk) begin
        if (rst)                bit9_q <= 1'b0;
        else if (load && mode9) bit9_q <= din[DW];
      end
    end else begin : g_no_ninth
      assign bit9_q = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/rxsf_tx_buf.sv
module rxsf_tx_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= din;
  end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import rxsf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter bit NINTH_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch_done,
  input  logic [DATA_W:0]   ch_bits,
  input  logic              ch_noise,
  input  logic              ch_stop_ok,
  input  logic              rd_stat,
  input  logic              rd_data,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wr_din,
  input  logic              mode_we,
  input  logic              mode_din,
  output logic              rdrf_o,
  output logic              ovr_o,
  output logic              nf_o,
  output logic              fe_o,
  output logic              bit9_o,
  output logic              mode9_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [DATA_W-1:0] tx_data_o
);

  err_t err_q;
  err_t clr;
  logic load;

  always_ff @(posedge clk) begin
    if (rst)          mode9_o <= 1'b0;
    else if (mode_we) mode9_o <= mode_din;
  end

  rxsf_clear_seq u_clr (
    .clk     (clk),
    .rst     (rst),
    .rd_stat (rd_stat),
    .rd_data (rd_data),
    .err_i   (err_q),
    .clr_o   (clr)
  );

  rxsf_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .ch_done    (ch_done),
    .ch_noise   (ch_noise),
    .ch_stop_ok (ch_stop_ok),
    .rd_data    (rd_data),
    .clr_i      (clr),
    .rdrf_q     (rdrf_o),
    .err_q      (err_q),
    .load_o     (load)
  );

  rxsf_rx_buf #(.DW(DATA_W), .NINTH_EN(NINTH_EN)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .mode9  (mode9_o),
    .din    (ch_bits),
    .data_q (rx_data_o),
    .bit9_q (bit9_o)
  );

  rxsf_tx_buf #(.DW(DATA_W)) u_tx (
    .clk (clk),
    .rst (rst),
    .we  (wr_data),
    .din (wr_din),
    .q   (tx_data_o)
  );

  assign ovr_o = err_q.ovr;
  assign nf_o  = err_q.nf;
  assign fe_o  = err_q.fe;

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (ch_done && rdrf_o && !fe_o) |=> ($stable(rx_data_o) && ovr_o)); // R3
  AST_FE_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ch_done && fe_o) |=> $stable(rx_data_o)); // R6

endmodule

// File: tb/uart_rx_status_bench.sv
`timescale 1ns/1ps
module uart_rx_status_bench;

  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ch_done = 0, ch_noise = 0, ch_stop_ok = 1;
  logic [DW:0] ch_bits = '0;
  logic rd_stat = 0, rd_data = 0, wr_data = 0, mode_we = 0, mode_din = 0;
  logic [DW-1:0] wr_din = '0;
  logic rdrf_o, ovr_o, nf_o, fe_o, bit9_o, mode9_o;
  logic [DW-1:0] rx_data_o, tx_data_o;

  always #2 clk = ~clk;

  uart_rx_status u_uart_rx_status (
    .clk(clk), .rst(rst), .ch_done(ch_done), .ch_bits(ch_bits),
    .ch_noise(ch_noise), .ch_stop_ok(ch_stop_ok), .rd_stat(rd_stat),
    .rd_data(rd_data), .wr_data(wr_data), .wr_din(wr_din),
    .mode_we(mode_we), .mode_din(mode_din), .rdrf_o(rdrf_o), .ovr_o(ovr_o),
    .nf_o(nf_o), .fe_o(fe_o), .bit9_o(bit9_o), .mode9_o(mode9_o),
    .rx_data_o(rx_data_o), .tx_data_o(tx_data_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_rdrf, m_ovr, m_nf, m_fe, m_b9, m_mode, m_armed;
  bit [2:0] m_snap;
  int m_data, m_tx;

  always @(posedge clk) begin
    bit [2:0] clrm;
    bit ld, ov;
    if (rst) begin
      m_rdrf <= 0; m_ovr <= 0; m_nf <= 0; m_fe <= 0; m_b9 <= 0;
      m_mode <= 0; m_armed <= 0; m_snap <= 0; m_data <= 0; m_tx <= 0;
    end else begin
      clrm = (rd_data && m_armed) ? m_snap : 3'b000;
      ld = ch_done && !m_fe && !m_rdrf;
      ov = ch_done && !m_fe && m_rdrf;
      m_rdrf <= ld ? 1'b1 : (rd_data ? 1'b0 : m_rdrf);
      m_ovr <= (m_ovr && !clrm[2]) || ov;
      m_nf  <= (m_nf  && !clrm[1]) || (ld && ch_noise);
      m_fe  <= (m_fe  && !clrm[0]) || (ld && !ch_stop_ok);
      if (ld) m_data <= int'(ch_bits[DW-1:0]);
      if (ld && m_mode) m_b9 <= ch_bits[DW];
      if (mode_we) m_mode <= mode_din;
      if (wr_data) m_tx <= int'(wr_din);
      if (rd_stat) begin
        m_armed <= 1;
        m_snap <= {m_ovr, m_nf, m_fe};
      end else if (rd_data) m_armed <= 0;
    end
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2 rdrf", rdrf_o, m_rdrf);
      chk("R2 data", rx_data_o, m_data);
      chk("R3 ovr", ovr_o, m_ovr);
      chk("R4 nf", nf_o, m_nf);
      chk("R5 fe", fe_o, m_fe);
      chk("R10 bit9", bit9_o, m_b9);
      chk("R10 mode", mode9_o, m_mode);
      chk("R11 tx", tx_data_o, m_tx);
    end
  end

  task automatic idle();
    ch_done = 0; rd_stat = 0; rd_data = 0; wr_data = 0; mode_we = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic send(int bits, bit noise, bit stop_ok);
    ch_done = 1; ch_bits = bits[DW:0]; ch_noise = noise; ch_stop_ok = stop_ok;
    step();
  endtask

  task automatic rstat(); rd_stat = 1; step(); endtask
  task automatic rdat();  rd_data = 1; step(); endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 rdrf", rdrf_o, 0); chk("R1 ovr", ovr_o, 0);
    chk("R1 nf", nf_o, 0);     chk("R1 fe", fe_o, 0);
    chk("R1 data", rx_data_o, 0); chk("R1 tx", tx_data_o, 0);
    chk("R1 mode", mode9_o, 0);

    send('hA5, 0, 1);
    chk("R2 load data", rx_data_o, 'hA5); chk("R2 load rdrf", rdrf_o, 1);
    send('h3C, 0, 1);
    chk("R3 overrun flag", ovr_o, 1); chk("R3 data kept", rx_data_o, 'hA5);
    rstat(); rdat();
    chk("R7 ovr cleared", ovr_o, 0); chk("R8 rdrf cleared", rdrf_o, 0);

    send('h11, 1, 0);
    chk("R4 nf with rdrf", nf_o, 1); chk("R5 fe set", fe_o, 1);
    chk("R5 rdrf set", rdrf_o, 1);
    rdat(); // unarmed
    chk("R8 fe kept", fe_o, 1); chk("R8 nf kept", nf_o, 1);
    chk("R8 rdrf cleared", rdrf_o, 0);
    send('h22, 0, 1);
    chk("R6 blocked data", rx_data_o, 'h11); chk("R6 blocked rdrf", rdrf_o, 0);
    chk("R6 no ovr", ovr_o, 0);
    rstat(); rdat();
    chk("R7 fe cleared", fe_o, 0); chk("R7 nf cleared", nf_o, 0);

    // flag set between status read and data read survives
    send('h33, 0, 1);
    rstat();
    send('h44, 1, 0);
    chk("R4 no nf on overrun", nf_o, 0);
    rdat();
    chk("R7 late ovr survives", ovr_o, 1); chk("R7 rdrf cleared", rdrf_o, 0);
    rstat(); rdat();
    chk("R7 ovr cleared", ovr_o, 0);

    // overrun with bad stop bit: only overrun
    send('h55, 0, 1);
    send('h66, 0, 0);
    chk("R5 ovr only", ovr_o, 1); chk("R5 fe clear", fe_o, 0);
    rstat(); rdat();

    // nine-bit mode
    mode_we = 1; mode_din = 1; step();
    send('h1AB, 0, 1);
    chk("R10 data", rx_data_o, 'hAB); chk("R10 bit9", bit9_o, 1);
    rdat();
    mode_we = 1; mode_din = 0; step();
    send('h0CD, 0, 1);
    chk("R10 bit9 held", bit9_o, 1); chk("R10 data", rx_data_o, 'hCD);

    // transmit write
    wr_data = 1; wr_din = 'h5A; step();
    chk("R11 tx", tx_data_o, 'h5A); chk("R11 rx untouched", rx_data_o, 'hCD);
    chk("R11 rdrf untouched", rdrf_o, 1);

    // R9: status and data read together
    send('h77, 0, 1);
    chk("R9 ovr set", ovr_o, 1);
    rd_stat = 1; rd_data = 1; step();
    chk("R9 ovr kept", ovr_o, 1); chk("R9 rdrf cleared", rdrf_o, 0);
    rdat();
    chk("R9 ovr cleared", ovr_o, 0);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      ch_done    = ($urandom_range(0, 3) == 0);
      ch_bits    = $urandom_range(0, 511);
      ch_noise   = ($urandom_range(0, 4) == 0);
      ch_stop_ok = ($urandom_range(0, 5) != 0);
      rd_stat    = ($urandom_range(0, 3) == 0);
      rd_data    = ($urandom_range(0, 3) == 0);
      wr_data    = ($urandom_range(0, 7) == 0);
      wr_din     = $urandom_range(0, 255);
      mode_we    = ($urandom_range(0, 15) == 0);
      mode_din   = $urandom_range(0, 1);
      @(negedge clk);
    end
    idle();
    @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule